// File: doc/BRIEF.md
# Single-Digit Decimal Subtractor with Sign and Magnitude Output

This combinational block subtracts one packed decimal digit from another and reports the result as a sign flag plus a decimal magnitude. Both operands must be valid digits in the range 0 to 9.

The subtraction works by complement addition:

- The subtrahend is turned into its nine's complement. Its bits are inverted and binary 1010 is added, and the carry out of that addition is dropped.
- The complement is added to the minuend in a decimal adder. The complement's lowest bit enters as the adder's carry-in, and a zero takes its place in the addend.
- The adder has a block-propagate bypass that passes the carry-in straight to the decimal carry output.
- A decimal carry out means the difference is positive. The magnitude is then the decimal sum plus the end-around carry.
- No decimal carry means the difference is negative, and the sum holds the nine's complement of the magnitude. A final 4-bit adder recomplements it: it inverts the sum and adds 1010, both gated by the inverted carry.
- Equal operands would give a negative zero. That case is folded to a positive zero.

The block holds no state. It is meant to be placed inside a larger decimal datapath, which registers the inputs and outputs.

Top module: `bcd_digit_sub`

## Requirements
- R1: When minuend > subtrahend, sign is 0 and mag equals minuend - subtrahend (e.g. 8 - 5 gives sign 0, mag 3).
- R2: When minuend < subtrahend, sign is 1 and mag equals subtrahend - minuend (e.g. 5 - 8 gives sign 1, mag 3).
- R3: When minuend equals subtrahend, sign is 0 and mag is 0; the block never reports sign 1 with mag 0.
- R4: For every pair of valid digit inputs, mag is a valid digit (at most 9).
- R5: The outputs follow the inputs with no clock; a new operand pair is reflected at the outputs without any clock edge.
- R6: A zero operand is handled: subtrahend 0 gives sign 0 and mag = minuend, and minuend 0 with subtrahend s > 0 gives sign 1 and mag = s.
- R7: The extreme pairs are exact: 9 - 0 gives sign 0 and mag 9, and 0 - 9 gives sign 1 and mag 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| minuend | input | 4 | Decimal digit the other operand is taken from, 0 to 9 |
| subtrahend | input | 4 | Decimal digit subtracted, 0 to 9 |
| sign | output | 1 | 1 when the difference is negative |
| mag | output | 4 | Decimal magnitude of the difference |

## Verification
The bench sweeps all 100 digit pairs. This separates the path where the decimal adder carries out (end-around carry) from the path where it does not (recomplement).

It then adds seeded random pairs, which also vary the order of operand changes. Directed cases cover:
- equal operands, which expose a negative-zero fault;
- zero operands and the 9/0 extremes, which drive the complementer and the bypass carry to their limits;
- a change of inputs with no clock edge, which shows the block is purely combinational.

// File: rtl/bcd_digit_sub.sv
module bcd_digit_sub #(
  parameter int W = 4
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic         sign,
  output logic [W-1:0] mag
);

  localparam logic [W-1:0] TEN = W'(10);
  localparam logic [W-1:0] SIX = W'(6);

  // nine's complement: invert, add ten, drop carry
  logic [W-1:0] inv_sub, nc;
  assign inv_sub = ~subtrahend;
  assign nc      = inv_sub + TEN;

  // decimal adder, first level: ripple full adders
  logic [W-1:0] addend, bsum, prop;
  logic [W:0]   rc;
  assign addend = {nc[W-1:1], 1'b0};
  assign rc[0]  = nc[0];

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign prop[i]  = minuend[i] ^ addend[i];
    assign bsum[i]  = prop[i] ^ rc[i];
    assign rc[i+1]  = (minuend[i] & addend[i]) | (prop[i] & rc[i]);
  end

  logic blk_p, dcarry;
  assign blk_p  = &prop;
  assign dcarry = (blk_p & rc[0]) | rc[W] | (bsum[3] & (bsum[2] | bsum[1]));

  // second level: add six when a decimal carry occurred
  logic [W-1:0] dsum;
  assign dsum = bsum + (dcarry ? SIX : '0);

  // correction: end-around carry or recomplement
  logic         ndc;
  logic [W-1:0] cor_a, cor_b, res;
  assign ndc   = ~dcarry;
  assign cor_a = dsum ^ {W{ndc}};
  assign cor_b = {ndc, 1'b0, ndc, 1'b0};
  assign res   = cor_a + cor_b + W'(dcarry);

  assign mag  = res;
  assign sign = ndc & (|res);

endmodule

// File: rtl/bcd_digit_sub_chk.sv
module bcd_digit_sub_chk (
  input logic [3:0] minuend,
  input logic [3:0] subtrahend,
  input logic       sign,
  input logic [3:0] mag
);

  logic ok_in;
  assign ok_in = (minuend <= 4'd9) && (subtrahend <= 4'd9);

  always_comb begin
    if (ok_in && minuend > subtrahend)
      AST_POS_RESULT: assert (!sign && mag == minuend - subtrahend); // R1
    if (ok_in && minuend < subtrahend)
      AST_NEG_RESULT: assert (sign && mag == subtrahend - minuend); // R2
    if (ok_in && minuend == subtrahend)
      AST_EQUAL_ZERO: assert (!sign && mag == 4'd0); // R3
    if (ok_in)
      AST_NO_NEG_ZERO: assert (!(sign && mag == 4'd0)); // R3
    if (ok_in)
      AST_MAG_DIGIT: assert (mag <= 4'd9); // R4
  end

endmodule

bind bcd_digit_sub bcd_digit_sub_chk u_chk (
  .minuend(minuend),
  .subtrahend(subtrahend),
  .sign(sign),
  .mag(mag)
);

// File: tb/bcd_digit_sub_test.sv
module bcd_digit_sub_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a = 4'd0, b = 4'd0;
  logic       sign;
  logic [3:0] mag;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  bcd_digit_sub uut (.minuend(a), .subtrahend(b), .sign(sign), .mag(mag));

  function automatic logic exp_sign(int x, int y);
    return x < y;
  endfunction

  function automatic logic [3:0] exp_mag(int x, int y);
    return 4'((x >= y) ? x - y : y - x);
  endfunction

  task automatic check(string req);
    logic       es = exp_sign(a, b);
    logic [3:0] em = exp_mag(a, b);
    checks++;
    if (sign !== es || mag !== em || mag > 4'd9) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d actual sign=%0d mag=%0d expected sign=%0d mag=%0d",
               req, a, b, sign, mag, es, em);
    end
  endtask

  function automatic string req_of(int x, int y);
    if (x > y) return "R1";
    if (x < y) return "R2";
    return "R3";
  endfunction

  task automatic apply(int x, int y, string req);
    @(posedge clk);
    a = 4'(x);
    b = 4'(y);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R3 reset state");

    apply(8, 5, "R1");
    apply(5, 8, "R2");
    apply(7, 7, "R3");
    apply(9, 0, "R7");
    apply(0, 9, "R7");
    apply(0, 0, "R3");
    apply(9, 9, "R3");
    for (int i = 1; i < 10; i++) apply(i, 0, "R6");
    for (int i = 1; i < 10; i++) apply(0, i, "R6");

    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++)
        apply(x, y, {req_of(x, y), " R4"});

    void'($urandom(32'd1234));
    for (int k = 0; k < 300; k++) begin
      int x = int'($urandom % 10);
      int y = int'($urandom % 10);
      apply(x, y, req_of(x, y));
    end

    // R5: outputs follow inputs between clock edges
    @(negedge clk);
    a = 4'd3; b = 4'd6;
    #1 check("R5");
    a = 4'd6; b = 4'd3;
    #1 check("R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule